// File: doc/BRIEF.md
# Converter Serial Output Sequencer

This block is the digital output side of a delta-sigma converter that makes its own serial clock. It goes through three phases in a loop. In the busy phase a conversion runs. In the sleep phase the outputs rest low for a fixed time. In the output phase the block toggles its serial clock and shifts a 32-bit frame out on the data pin, most significant bit first. The first bit of the frame is the end-of-conversion flag.

A one-cycle `convDone` strobe stands in for the modulator and ends the busy phase. The 32-bit `resultWord` is captured when the output phase begins. Chip select has two uses. When it is tied low, conversions repeat without end over just two wires. A rising edge on chip select during the output phase cuts the frame short and starts a new conversion at once. If that abort comes before five clock rising edges, the block reports the edge count so that the next conversion setting can be chosen from it. The mode input allows or holds back the self-clocked output phase.

Top module: `serialOutSeq`

## Requirements
- R1: During a conversion, and after reset, `busyOut`, `sckOut` and `sdoOut` are all 1.
- R2: In the cycle after `convDone` is sampled high in the conversion phase, `busyOut`, `sckOut` and `sdoOut` are all 0.
- R3: With `intClkSel` = 1, the span from the fall of `busyOut` to the first rising edge of `sckOut` lasts exactly SLEEP_CYC + SCK_HALF clock cycles. No external request is needed to start the output.
- R4: In the output phase `sckOut` has a half period of SCK_HALF cycles and gives exactly 32 rising edges. The bits on `sdoOut` at those edges, in order, are: 0 (the end-of-conversion flag, which takes the place of `resultWord[31]`), then `resultWord[30]` down to `resultWord[0]`.
- R5: `sdoOut` changes only when `sckOut` falls; it is stable while `sckOut` stays high within a frame.
- R6: After the 32nd rising edge, `sckOut` stays high for SCK_HALF cycles. `busyOut` and `sdoOut` then go to 1 and `sckOut` stays at 1.
- R7: A rising edge on `csIn` during the output phase puts the block back in the conversion phase one cycle later. This applies once 1 to 32 rising edges of `sckOut` have been seen. A rising edge on `csIn` in the output phase before the first rising edge has no effect on the frame.
- R8: An abort after 1 to 4 rising edges sets `setOverride` = 1 and `setEdges` = that count. An abort after 5 or more edges sets both to 0. A frame that completes normally clears both to 0.
- R9: While `intClkSel` = 0, the block stays in sleep after the sleep time with `busyOut` and `sckOut` at 0. It starts the output phase once `intClkSel` is 1.
- R10: A `convDone` pulse outside the conversion phase has no effect; a frame that receives one still carries the correct bits.
- R11: `sdoOe` is the inverse of `csIn` at all times, so a high chip select makes the data pin high-impedance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| convDone | input | 1 | One-cycle strobe: the conversion has finished |
| resultWord | input | WORD_W | Conversion result, loaded when the output phase begins |
| csIn | input | 1 | Chip select; a rising edge aborts the output phase |
| intClkSel | input | 1 | 1 lets the self-clocked output phase run |
| sckOut | output | 1 | Generated serial clock |
| sdoOut | output | 1 | Serial data / end-of-conversion flag |
| sdoOe | output | 1 | Output enable for the data pin |
| busyOut | output | 1 | High while a conversion runs |
| setOverride | output | 1 | The last abort was early enough to pick the next setting |
| setEdges | output | $clog2(WORD_W+1) | Count of rising edges seen before that early abort |

## Verification
The bench builds the block with SCK_HALF = 3 and SLEEP_CYC = 20, and keeps the 32-bit word. The short sleep brings about sixty frames into a short run. The three-cycle half period leaves a cycle inside the first low half of the clock. In that cycle a chip-select edge can land in the output phase before any rising edge, which exercises the case that must be ignored. Each abort count from 1 to 5 is driven directly, and so is an abort after the 32nd edge. Random frames mix in further abort points.

// File: rtl/serialOutSeqPkg.sv
package serialOutSeqPkg;

  typedef enum logic [1:0] {
    PH_CONV  = 2'd0,
    PH_SLEEP = 2'd1,
    PH_OUT   = 2'd2
  } phase_t;

  typedef struct packed {
    logic enterConv;
    logic enterSleep;
    logic loadFrame;
    logic riseSck;
    logic fallSck;
  } seqStrobe_t;

endpackage

// File: rtl/serialOutSeqCtrl.sv
module serialOutSeqCtrl
  import serialOutSeqPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int SCK_HALF  = 2,
  parameter int SLEEP_CYC = 50,
  parameter int EDGE_MIN  = 5,
  localparam int EW = $clog2(WORD_W + 1),
  localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1,
  localparam int SW = (SLEEP_CYC > 1) ? $clog2(SLEEP_CYC) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          convDone,
  input  logic          csIn,
  input  logic          intClkSel,
  input  logic          sckLvl,
  output seqStrobe_t    stb,
  output logic          busy,
  output logic          setOverride,
  output logic [EW-1:0] setEdges
);

  localparam logic [HW-1:0] HALF_RELOAD  = HW'(SCK_HALF - 1);
  localparam logic [SW-1:0] SLEEP_RELOAD = SW'(SLEEP_CYC - 1);
  localparam logic [EW-1:0] LAST_EDGE    = EW'(WORD_W);
  localparam logic [EW-1:0] MIN_EDGE     = EW'(EDGE_MIN);

  phase_t        state;
  logic [HW-1:0] halfCnt;
  logic [SW-1:0] sleepCnt;
  logic [EW-1:0] edgeCnt;
  logic          csPrev;
  logic          csRise;
  logic          abortHit;
  logic          halfDone;

  assign csRise   = csIn & ~csPrev;
  assign abortHit = (state == PH_OUT) && csRise && (edgeCnt != '0);
  assign halfDone = (halfCnt == '0);
  assign busy     = (state == PH_CONV);

  always_comb begin
    stb = '0;
    unique case (state)
      PH_CONV:  stb.enterSleep = convDone;
      PH_SLEEP: stb.loadFrame  = (sleepCnt == '0) && intClkSel;
      PH_OUT: begin
        if (abortHit) begin
          stb.enterConv = 1'b1;
        end else if (halfDone) begin
          if (!sckLvl)                    stb.riseSck   = 1'b1;
          else if (edgeCnt == LAST_EDGE)  stb.enterConv = 1'b1;
          else                            stb.fallSck   = 1'b1;
        end
      end
      default: stb = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= PH_CONV;
      halfCnt     <= HALF_RELOAD;
      sleepCnt    <= SLEEP_RELOAD;
      edgeCnt     <= '0;
      csPrev      <= 1'b1;
      setOverride <= 1'b0;
      setEdges    <= '0;
    end else begin
      csPrev <= csIn;
      unique case (state)
        PH_CONV: begin
          if (stb.enterSleep) begin
            state    <= PH_SLEEP;
            sleepCnt <= SLEEP_RELOAD;
          end
        end
        PH_SLEEP: begin
          if (sleepCnt != '0) begin
            sleepCnt <= sleepCnt - 1'b1;
          end else if (stb.loadFrame) begin
            state   <= PH_OUT;
            halfCnt <= HALF_RELOAD;
            edgeCnt <= '0;
          end
        end
        PH_OUT: begin
          if (abortHit) begin
            state       <= PH_CONV;
            setOverride <= (edgeCnt < MIN_EDGE);
            setEdges    <= (edgeCnt < MIN_EDGE) ? edgeCnt : '0;
          end else if (halfDone) begin
            halfCnt <= HALF_RELOAD;
            if (stb.riseSck) edgeCnt <= edgeCnt + 1'b1;
            if (stb.enterConv) begin
              state       <= PH_CONV;
              setOverride <= 1'b0;
              setEdges    <= '0;
            end
          end else begin
            halfCnt <= halfCnt - 1'b1;
          end
        end
        default: state <= PH_CONV;
      endcase
    end
  end

  p_edge_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= LAST_EDGE);

  p_abort_restart_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_OUT && csRise && edgeCnt != '0) |=> (state == PH_CONV));

  p_hold_sleep_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_SLEEP && !intClkSel) |=> (state == PH_SLEEP));

  p_done_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_SLEEP && convDone) |=> (state != PH_CONV));

  p_override_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    setOverride |-> (setEdges != '0 && setEdges < MIN_EDGE));

endmodule

// File: rtl/serialOutSeqData.sv
module serialOutSeqData
  import serialOutSeqPkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic [WORD_W-1:0] resultWord,
  output logic              sckLvl,
  output logic              sdoLvl
);

  logic [WORD_W-1:0] shReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckLvl <= 1'b1;
      sdoLvl <= 1'b1;
      shReg  <= '0;
    end else begin
      if (stb.enterConv) begin
        sckLvl <= 1'b1;
        sdoLvl <= 1'b1;
      end
      if (stb.enterSleep) begin
        sckLvl <= 1'b0;
        sdoLvl <= 1'b0;
      end
      if (stb.loadFrame) begin
        shReg  <= {1'b0, resultWord[WORD_W-2:0]};
        sdoLvl <= 1'b0;
      end
      if (stb.riseSck) sckLvl <= 1'b1;
      if (stb.fallSck) begin
        sckLvl <= 1'b0;
        shReg  <= {shReg[WORD_W-2:0], 1'b0};
        sdoLvl <= shReg[WORD_W-2];
      end
    end
  end

  p_sdo_hold_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sckLvl && $past(sckLvl) && !$past(stb.enterConv)) |-> $stable(sdoLvl));

endmodule

// File: rtl/serialOutSeq.sv
module serialOutSeq
  import serialOutSeqPkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int SCK_HALF  = 2,
  parameter int SLEEP_CYC = 50,
  parameter int EDGE_MIN  = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       convDone,
  input  logic [WORD_W-1:0]          resultWord,
  input  logic                       csIn,
  input  logic                       intClkSel,
  output logic                       sckOut,
  output logic                       sdoOut,
  output logic                       sdoOe,
  output logic                       busyOut,
  output logic                       setOverride,
  output logic [$clog2(WORD_W+1)-1:0] setEdges
);

  seqStrobe_t stb;
  logic       sckLvl;
  logic       sdoLvl;

  serialOutSeqCtrl #(
    .WORD_W(WORD_W), .SCK_HALF(SCK_HALF),
    .SLEEP_CYC(SLEEP_CYC), .EDGE_MIN(EDGE_MIN)
  ) ctrl (
    .clk(clk), .rstN(rstN), .convDone(convDone), .csIn(csIn),
    .intClkSel(intClkSel), .sckLvl(sckLvl), .stb(stb), .busy(busyOut),
    .setOverride(setOverride), .setEdges(setEdges)
  );

  serialOutSeqData #(.WORD_W(WORD_W)) data (
    .clk(clk), .rstN(rstN), .stb(stb), .resultWord(resultWord),
    .sckLvl(sckLvl), .sdoLvl(sdoLvl)
  );

  assign sckOut = sckLvl;
  assign sdoOut = sdoLvl;
  assign sdoOe  = ~csIn;

  p_conv_levels_r1: assert property (@(posedge clk) disable iff (!rstN)
    busyOut |-> (sckOut && sdoOut));

  p_sleep_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busyOut && convDone) |=> (!busyOut && !sckOut && !sdoOut));

endmodule

// File: tb/serialOutSeq_test.sv
module serialOutSeq_test;

  localparam int W     = 32;
  localparam int HALF  = 3;
  localparam int SLEEP = 20;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         convDone = 1'b0;
  logic [W-1:0] resultWord = '0;
  logic         csIn = 1'b0;
  logic         intClkSel = 1'b1;
  logic         sckOut, sdoOut, sdoOe, busyOut, setOverride;
  logic [5:0]   setEdges;

  int checks = 0;
  int fails = 0;
  int riseCnt = 0;
  int cyc = 0;
  int rise1Cyc = 0;
  int rise2Cyc = 0;
  logic prevSck = 1'b1;
  logic prevSdo = 1'b1;
  logic holdBad = 1'b0;
  logic [W-1:0] cap = '0;

  always #5 clk = ~clk;

  serialOutSeq #(.WORD_W(W), .SCK_HALF(HALF), .SLEEP_CYC(SLEEP), .EDGE_MIN(5)) uut (
    .clk(clk), .rstN(rstN), .convDone(convDone), .resultWord(resultWord),
    .csIn(csIn), .intClkSel(intClkSel), .sckOut(sckOut), .sdoOut(sdoOut),
    .sdoOe(sdoOe), .busyOut(busyOut), .setOverride(setOverride), .setEdges(setEdges)
  );

  function automatic logic [W-1:0] frameOf(input logic [W-1:0] w);
    return {1'b0, w[W-2:0]};
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (sckOut && !prevSck && !busyOut) begin
      riseCnt++;
      cap = {cap[W-2:0], sdoOut};
      if (riseCnt == 1) rise1Cyc = cyc;
      if (riseCnt == 2) rise2Cyc = cyc;
    end
    if (prevSck && sckOut && !busyOut && sdoOut != prevSdo) holdBad = 1'b1;
    check(sdoOe === !csIn, "R11 sdoOe", sdoOe, !csIn);
    prevSck = sckOut;
    prevSdo = sdoOut;
  endtask

  task automatic doFrame(input logic [W-1:0] word, input int abortK,
                         input bit modeHold, input bit csEarly, input bit doneGlitch);
    int lowCnt;
    int n;
    bit bad;
    intClkSel  = !modeHold;
    resultWord = word;
    repeat (2) step();
    check(busyOut && sckOut && sdoOut, "R1 conversion levels",
          {busyOut, sckOut, sdoOut}, 3'b111);
    riseCnt = 0;
    holdBad = 1'b0;
    convDone = 1'b1;
    step();
    convDone = 1'b0;
    check(!busyOut && !sckOut && !sdoOut, "R2 sleep levels",
          {busyOut, sckOut, sdoOut}, 3'b000);
    if (modeHold) begin
      bad = 1'b0;
      repeat (SLEEP + 40) begin
        step();
        if (sckOut || busyOut) bad = 1'b1;
      end
      check(!bad, "R9 held in sleep", bad, 0);
      intClkSel = 1'b1;
      n = 0;
      while (!sckOut && n < 100) begin step(); n++; end
    end else begin
      lowCnt = 1;
      while (!sckOut && lowCnt < 200) begin
        if (csEarly && lowCnt == SLEEP + 1) csIn = 1'b1;
        if (csEarly && lowCnt == SLEEP + 2) csIn = 1'b0;
        step();
        if (!sckOut) lowCnt++;
      end
      check(lowCnt == SLEEP + HALF, "R3 sleep span", lowCnt, SLEEP + HALF);
    end
    while (1) begin
      if (abortK > 0 && riseCnt == abortK) begin
        csIn = 1'b1;
        step();
        check(busyOut && sckOut && sdoOut, "R7 abort restart",
              {busyOut, sckOut, sdoOut}, 3'b111);
        repeat (3) step();
        csIn = 1'b0;
        check(setOverride == (abortK < 5) && setEdges == ((abortK < 5) ? abortK : 0),
              "R8 abort setting", {setOverride, setEdges},
              {(abortK < 5), 6'((abortK < 5) ? abortK : 0)});
        step();
        return;
      end
      if (riseCnt >= W) break;
      convDone = (doneGlitch && riseCnt == 10);
      step();
      convDone = 1'b0;
    end
    check(cap == frameOf(word), "R4 frame bits", cap, frameOf(word));
    check(rise2Cyc - rise1Cyc == 2 * HALF, "R4 sck period", rise2Cyc - rise1Cyc, 2 * HALF);
    check(!holdBad, "R5 sdo stable while sck high", holdBad, 0);
    if (doneGlitch) check(cap == frameOf(word), "R10 stray done ignored", cap, frameOf(word));
    n = 0;
    while (!busyOut && n < 50) begin step(); n++; end
    check(n == HALF, "R6 tail length", n, HALF);
    check(sckOut && sdoOut, "R6 parked high", {sckOut, sdoOut}, 2'b11);
    check(!setOverride && setEdges == 0, "R8 cleared by full frame",
          {setOverride, setEdges}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int k;
    void'($urandom(32'h5EED_2B17));
    repeat (3) @(negedge clk);
    check(busyOut && sckOut && sdoOut, "R1 reset state", {busyOut, sckOut, sdoOut}, 3'b111);
    rstN = 1'b1;
    step();
    doFrame(32'hA5C3_0F1E, 0, 0, 0, 0);
    doFrame(32'hFFFF_FFFF, 0, 0, 0, 0);
    doFrame(32'h8000_0000, 0, 0, 0, 0);
    doFrame(32'h0000_0001, 0, 0, 1, 0);
    doFrame(32'h1234_5678, 0, 1, 0, 0);
    doFrame(32'h7654_3210, 0, 0, 0, 1);
    for (int a = 1; a <= 5; a++) begin
      doFrame($urandom, a, 0, 0, 0);
      doFrame($urandom, 0, 0, 0, 0);
    end
    doFrame($urandom, 3, 0, 0, 0);
    doFrame($urandom, 32, 0, 0, 0);
    doFrame($urandom, 0, 0, 0, 0);
    for (int i = 0; i < 45; i++) begin
      k = (($urandom % 4) == 0) ? (1 + ($urandom % 32)) : 0;
      doFrame($urandom, k, 0, ($urandom % 8) == 0, ($urandom % 6) == 0);
    end
    summary();
  end

endmodule